// File: doc/BRIEF.md
# Tone Guard Steering and Output Latch

This block sits behind a dual-tone frequency verifier. The verifier gives a raw tone-present flag and a 4-bit code. This block decides, by timing, when those raw signals form a real key press. A tone must stay present with an unchanged code for longer than a present guard time before it counts as a digit. Once a digit is accepted, it ends only after the tone has been absent for longer than an absent guard time. Shorter dropouts are bridged. Both guard times are counts of the system clock, set by parameters. A designer usually picks them so that they fall between the 20 ms reject limit and the 40 ms accept limit. The two guard times can be tuned separately.

When a digit is accepted, its code goes into an output register. That register drives a 4-bit bus, which is released to high-impedance whenever output-enable is low or power-down is high. A separate drive-enable output shows when the bus is driven. The steering strobe rises a programmable number of cycles after the new code appears on the bus, which gives a reader a setup margin of about 3.4 µs. The strobe falls when the absent guard time expires. The latched code stays put until the next accepted digit. Power-down returns the sequencer to its idle state at once.

The sequencer has five states:
- IDLE: no tone.
- QUAL: a tone is being timed against the present guard.
- SETUP: the code is latched and the strobe is held back.
- HELD: the strobe is high and the tone is present.
- GAP: the strobe is high and the tone is absent, while the absent guard is timed.

The transitions are:
- IDLE→QUAL when the flag is seen high.
- QUAL→IDLE when the flag drops.
- QUAL→QUAL with the count restarted when the code changes.
- QUAL→SETUP when the present guard expires.
- SETUP→HELD when the setup count expires.
- HELD→GAP when the flag drops.
- GAP→HELD when the flag returns.
- GAP→IDLE when the absent guard expires.
- Any state→IDLE under power-down.

In the requirements below, P is PRESENT_CYC, A is ABSENT_CYC and S is SETUP_CYC. A "sample" is one rising clock edge.

Top module: `tone_steer`

## Requirements
- R1: After reset, strobe is 0, the latched code is 4'h0, and with oe=1 and pwr_dn=0 the bus is driven (q_drive=1) with 4'h0.
- R2: If raw_valid is high for P+1 consecutive samples with the same raw_code, that code is latched. It appears on q_bus right after the (P+1)-th sample.
- R3: If raw_valid is high for P or fewer consecutive samples, no code is latched and strobe stays 0.
- R4: A change of raw_code while raw_valid is high restarts the present guard. The new code needs P+1 samples of its own, counted from the sample that carried the change.
- R5: strobe rises exactly S samples after the sample that latched the code, and the bus code does not change in between.
- R6: Once strobe is high, an absence of A or fewer samples is ignored. Strobe stays high, and the bus keeps its code even when the tone returns with a different code.
- R7: An absence of A+1 consecutive samples drops strobe right after the (A+1)-th absent sample. The latched code holds until the next accepted digit.
- R8: q_drive is 1 exactly when oe=1 and pwr_dn=0. While it is 1, q_bus carries the latched code; otherwise q_bus is high-impedance.
- R9: A sample with pwr_dn=1 clears strobe and the guard timing, and keeps the latched code. After pwr_dn falls, a continuing tone must qualify afresh over P+1 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that the guard times are counted in |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_valid | input | 1 | Tone-present flag from the frequency verifier |
| raw_code | input | 4 | Raw digit code from the frequency verifier |
| oe | input | 1 | Output enable for the code bus |
| pwr_dn | input | 1 | Power-down: clears the sequencer and releases the bus |
| q_bus | output | 4 | Three-state latched digit code |
| q_drive | output | 1 | High while q_bus is actively driven |
| strobe | output | 1 | Delayed steering strobe marking a valid digit |

## Verification
A sequencer stuck in the wrong state, or a guard counter off by one, shows at the ports within one guard window. The code appears on the bus one sample early or late, or the strobe edge moves from its expected sample. For this reason the bench checks q_bus and strobe on every cycle around each threshold instead of only at the end of a digit. A candidate code that is not refreshed on a code change, or a HELD state that does not ignore the code input, shows up as a wrong value on q_bus after the next strobe edge. Power-down errors show one cycle after pwr_dn rises, as a strobe or q_drive that stays high.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_QUAL  = 3'd1,
        ST_SETUP = 3'd2,
        ST_HELD  = 3'd3,
        ST_GAP   = 3'd4
    } steer_state_e;

endpackage

// File: rtl/steer_timer.sv
module steer_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R3
    clr_inc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr && inc));

endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
#(
    parameter int PRESENT_CYC = 8,
    parameter int ABSENT_CYC  = 8,
    parameter int SETUP_CYC   = 4,
    parameter int CODE_W      = 4,
    parameter int CNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_dn,
    input  logic              raw_valid,
    input  logic [CODE_W-1:0] raw_code,
    input  logic [CNT_W-1:0]  cnt,
    output steer_state_e      state,
    output logic              cnt_clr,
    output logic              cnt_inc,
    output logic              latch_en,
    output logic [CODE_W-1:0] latch_code,
    output logic              strobe
);

    localparam logic [CNT_W-1:0] P_LAST = CNT_W'(PRESENT_CYC - 1);
    localparam logic [CNT_W-1:0] A_LAST = CNT_W'(ABSENT_CYC - 1);
    localparam logic [CNT_W-1:0] S_LAST = CNT_W'(SETUP_CYC - 1);

    steer_state_e      nxt;
    logic [CODE_W-1:0] cand;

    // candidate code tracks the raw code while a tone is being qualified
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand <= '0;
        end else if (!pwr_dn && raw_valid &&
                     (state == ST_IDLE || state == ST_QUAL)) begin
            cand <= raw_code;
        end
    end

    always_comb begin
        nxt      = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        latch_en = 1'b0;
        if (pwr_dn) begin
            nxt     = ST_IDLE;
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_clr = 1'b1;
                    if (raw_valid) nxt = ST_QUAL;
                end
                ST_QUAL: begin
                    if (!raw_valid) begin
                        nxt     = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else if (raw_code != cand) begin
                        cnt_clr = 1'b1;
                    end else if (cnt == P_LAST) begin
                        latch_en = 1'b1;
                        nxt      = ST_SETUP;
                        cnt_clr  = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_SETUP: begin
                    if (cnt == S_LAST) begin
                        nxt     = ST_HELD;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_HELD: begin
                    cnt_clr = 1'b1;
                    if (!raw_valid) nxt = ST_GAP;
                end
                ST_GAP: begin
                    if (raw_valid) begin
                        nxt     = ST_HELD;
                        cnt_clr = 1'b1;
                    end else if (cnt == A_LAST) begin
                        nxt     = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    nxt     = ST_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        latch_code = cand;
        strobe     = (state == ST_HELD) || (state == ST_GAP);
    end

    // R6
    gap_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> ($past(state) == ST_HELD || $past(state) == ST_GAP));

    // R5
    strobe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> ($past(state) == ST_SETUP));

    // R9
    pwr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (state == ST_IDLE));

endmodule

// File: rtl/steer_outstage.sv
module steer_outstage #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [CODE_W-1:0] latch_code,
    input  logic              oe,
    input  logic              pwr_dn,
    output logic [CODE_W-1:0] code_q,
    output logic              q_drive,
    output wire  [CODE_W-1:0] q_bus
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (latch_en) begin
            code_q <= latch_code;
        end
    end

    assign q_drive = oe && !pwr_dn;

    for (genvar b = 0; b < CODE_W; b++) begin : g_drv
        assign q_bus[b] = q_drive ? code_q[b] : 1'bz;
    end

endmodule

// File: rtl/tone_steer.sv
module tone_steer
    import steer_pkg::*;
#(
    parameter int PRESENT_CYC = 30000,
    parameter int ABSENT_CYC  = 30000,
    parameter int SETUP_CYC   = 4,
    parameter int CODE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              raw_valid,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              oe,
    input  logic              pwr_dn,
    output wire  [CODE_W-1:0] q_bus,
    output logic              q_drive,
    output logic              strobe
);

    localparam int PA_MAX  = (PRESENT_CYC > ABSENT_CYC) ? PRESENT_CYC : ABSENT_CYC;
    localparam int LIM_MAX = (PA_MAX > SETUP_CYC) ? PA_MAX : SETUP_CYC;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);

    steer_state_e      state;
    logic              cnt_clr;
    logic              cnt_inc;
    logic              latch_en;
    logic [CODE_W-1:0] latch_code;
    logic [CODE_W-1:0] code_q;
    logic [CNT_W-1:0]  cnt;

    steer_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    steer_fsm #(
        .PRESENT_CYC (PRESENT_CYC),
        .ABSENT_CYC  (ABSENT_CYC),
        .SETUP_CYC   (SETUP_CYC),
        .CODE_W      (CODE_W),
        .CNT_W       (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_dn     (pwr_dn),
        .raw_valid  (raw_valid),
        .raw_code   (raw_code),
        .cnt        (cnt),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .latch_en   (latch_en),
        .latch_code (latch_code),
        .strobe     (strobe)
    );

    steer_outstage #(.CODE_W(CODE_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_en   (latch_en),
        .latch_code (latch_code),
        .oe         (oe),
        .pwr_dn     (pwr_dn),
        .code_q     (code_q),
        .q_drive    (q_drive),
        .q_bus      (q_bus)
    );

    // R5
    strobe_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe) |-> $stable(code_q));

    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_q) |-> (state == ST_SETUP));

endmodule

// File: tb/tb_tone_steer.sv
`timescale 1ns/1ps
module tb_tone_steer;

    localparam int P = 8;
    localparam int A = 6;
    localparam int S = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       raw_valid;
    logic [3:0] raw_code;
    logic       oe;
    logic       pwr_dn;
    wire  [3:0] q_bus;
    logic       q_drive;
    logic       strobe;

    int n_chk  = 0;
    int n_bad  = 0;
    int last   = 0;
    bit closed = 1'b0;

    always #2 clk = ~clk;

    tone_steer #(.PRESENT_CYC(P), .ABSENT_CYC(A), .SETUP_CYC(S), .CODE_W(4)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .raw_valid (raw_valid),
        .raw_code  (raw_code),
        .oe        (oe),
        .pwr_dn    (pwr_dn),
        .q_bus     (q_bus),
        .q_drive   (q_drive),
        .strobe    (strobe)
    );

    function automatic bit exp_accept(int len);
        return len > P;
    endfunction

    function automatic int exp_bus(bit acc, int c, int prev);
        return acc ? c : prev;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trial(int c, int len, string req);
        bit seen = 1'b0;
        bit acc;
        raw_valid = 1'b1;
        raw_code  = 4'(c);
        repeat (len) begin
            @(negedge clk);
            seen |= strobe;
        end
        raw_valid = 1'b0;
        repeat (P + S + A + 4) begin
            @(negedge clk);
            seen |= strobe;
        end
        acc = exp_accept(len);
        chk(req, "strobe seen", int'(seen), int'(acc));
        chk(req, "bus code", int'(q_bus), exp_bus(acc, c, last));
        chk("R7", "strobe idle after trial", int'(strobe), 0);
        last = exp_bus(acc, c, last);
    endtask

    initial begin
        cyc(20000);
        if (!closed) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; raw_valid = 1'b0; raw_code = 4'h0; oe = 1'b1; pwr_dn = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1 reset state
        chk("R1", "strobe", int'(strobe), 0);
        chk("R1", "q_drive", int'(q_drive), 1);
        chk("R1", "bus code", int'(q_bus), 0);

        // R2 and R5: cycle-exact acceptance and strobe setup
        raw_code = 4'd5; raw_valid = 1'b1;
        for (int i = 0; i <= P + S + 1; i++) begin
            @(negedge clk);
            chk("R2", "bus at sample", int'(q_bus), (i >= P) ? 5 : 0);
            chk("R5", "strobe at sample", int'(strobe), (i >= P + S) ? 1 : 0);
        end
        last = 5;

        // R6: short gap bridged, new code ignored
        raw_valid = 1'b0;
        repeat (A) begin
            @(negedge clk);
            chk("R6", "strobe in short gap", int'(strobe), 1);
        end
        raw_valid = 1'b1; raw_code = 4'd9;
        cyc(3);
        chk("R6", "strobe after gap", int'(strobe), 1);
        chk("R6", "bus after gap", int'(q_bus), 5);

        // R7: long gap ends digit
        raw_valid = 1'b0;
        for (int i = 0; i <= A + 1; i++) begin
            @(negedge clk);
            chk("R7", "strobe in long gap", int'(strobe), (i < A) ? 1 : 0);
        end
        chk("R7", "code held", int'(q_bus), 5);

        // R3 and R2 boundary
        trial(3, P, "R3");
        trial(11, 1, "R3");
        trial(6, P + 1, "R2");

        // R4: code change restarts present guard
        raw_valid = 1'b1; raw_code = 4'd10;
        cyc(P);
        raw_code = 4'd12;
        cyc(P);
        chk("R4", "bus before restart expiry", int'(q_bus), last);
        chk("R4", "strobe before restart expiry", int'(strobe), 0);
        cyc(1);
        chk("R4", "bus at restart expiry", int'(q_bus), 12);
        raw_valid = 1'b0;
        cyc(S + A + 4);
        last = 12;
        chk("R4", "strobe idle", int'(strobe), 0);

        // R8: output enable
        oe = 1'b0;
        cyc(1);
        chk("R8", "q_drive oe low", int'(q_drive), 0);
        oe = 1'b1;
        cyc(1);
        chk("R8", "q_drive oe high", int'(q_drive), 1);
        chk("R8", "bus oe high", int'(q_bus), last);

        // R9: power-down
        raw_valid = 1'b1; raw_code = 4'd7;
        cyc(P + S + 2);
        chk("R9", "strobe before pd", int'(strobe), 1);
        pwr_dn = 1'b1;
        cyc(1);
        chk("R9", "strobe in pd", int'(strobe), 0);
        chk("R9", "q_drive in pd", int'(q_drive), 0);
        cyc(3);
        pwr_dn = 1'b0;
        cyc(P);
        chk("R9", "strobe requalify", int'(strobe), 0);
        chk("R9", "code kept", int'(q_bus), 7);
        raw_valid = 1'b0;
        cyc(P + S + A + 4);
        last = 7;

        // random tone lengths
        for (int k = 0; k < 40; k++) begin
            int len = 1 + int'($urandom % (2 * P + 2));
            int c   = int'($urandom % 16);
            trial(c, len, exp_accept(len) ? "R2" : "R3");
        end

        closed = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule